// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the command port of a parallel NOR-style flash and decodes the multi-write command sequences that reach it. Each bus write arrives as a one-clock strobe with an address and a data word. Only the low byte of the data word carries the command value. The decoder tracks which read view the host sees: the array, the identifier view or the query view. It recognises the single-location, paired-word and four-byte program sequences, and it runs the shortened unlock-bypass command set. When a program sequence completes, it hands a start pulse, an operation code, the aligned target address and the packed data to an external program engine. It then ignores every write until that engine drops its busy line.

A program aimed at a protected block is dropped without a start pulse and without an error. A block is protected when its protection bit is set. When the write-protect pin is low, the two highest-numbered blocks are also protected. The engine's failure pulse sets a sticky error flag, and a reset command clears it. When the high-voltage pin rises, the decoder enters bypass mode. When the pin falls, the decoder returns to normal array reads.

The FSM has eight states:

| State | Meaning |
|---|---|
| `S_IDLE` | normal idle |
| `S_UNL1` | first unlock write seen |
| `S_UNL2` | second unlock write seen |
| `S_PROG` | waiting for the program address and data |
| `S_FAST` | collecting the writes of a paired-word or four-byte program |
| `S_BYP_IDLE` | bypass idle |
| `S_BYP_PROG` | waiting for the bypass program address and data |
| `S_BYP_EXIT` | waiting for the second write of the bypass exit |

Its transitions are:

- IDLE→UNL1: unlock write 1.
- UNL1→UNL2: unlock write 2.
- UNL2→PROG: the program command.
- UNL2→BYP_IDLE: the bypass command.
- UNL2→IDLE: reset or identifier command, or any other write.
- IDLE→FAST: the fast setup write.
- FAST→FAST: further lane writes.
- FAST→IDLE: the last lane write, or a misaligned lane write.
- PROG→IDLE: the data write.
- BYP_IDLE→BYP_PROG: the program command.
- BYP_IDLE→BYP_EXIT: the identifier command.
- BYP_PROG→BYP_IDLE: the data write.
- BYP_EXIT→IDLE: the exit value.
- BYP_EXIT→BYP_IDLE: any other value.
- Any state→BYP_IDLE: the high-voltage pin rises.
- Any state→IDLE: the high-voltage pin falls.

Any unexpected write in a normal state returns the decoder to `S_IDLE` with the array view.

Top module: `flash_cmd_decoder`

## Requirements
- R1: In a normal state, a write that fits no sequence step returns the decoder to idle with `read_mode_o` = 2'b00 (array), and it issues no start.
- R2: A reset command (low byte 0xF0) clears `err_o`. It may come as a single write at any address, or as a third write after the two unlock writes. From the query view it restores the view that was active before the query; from any other view it selects the array view.
- R3: The standard program is four writes: 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555, then address/data. One cycle after the fourth write, `start_o` pulses for one cycle with `op_code_o` = 2'b00, `op_addr_o` = that address and `op_data_o` = the zero-extended data.
- R4: With `word_mode` = 0, the setup write 0x50@0x555 is followed by four byte writes. Each byte lands in lane addr[1:0] of `op_data_o` (lane k occupies bits 8k+7:8k). One cycle after the fifth write, `start_o` pulses with `op_code_o` = 2'b10 and `op_addr_o` = the first address with bits 1:0 cleared. A later write whose address differs from the first above bit 1 aborts the sequence as in R1.
- R5: With `word_mode` = 1, the setup write 0x50@0x555 is followed by two 16-bit writes. Each word lands in lane addr[0] (lane 0 occupies bits 15:0, lane 1 occupies bits 31:16). One cycle after the third write, `start_o` pulses with `op_code_o` = 2'b01 and bit 0 of the address cleared. A second address differing above bit 0 aborts the sequence.
- R6: The three writes 0xAA@0x555, 0x55@0x2AA, 0x20@0x555 set `bypass_o`. In bypass, 0xA0 followed by address/data starts a program with `op_code_o` = 2'b00. 0x90 followed by 0x00 leaves bypass and clears `err_o`. A 0xF0 write has no effect.
- R7: One cycle after `hv_pin` is seen high, `bypass_o` is 1, and the exit pair does not leave bypass while the pin stays high. The cycle after the pin falls, `bypass_o` is 0 and `read_mode_o` is the array view.
- R8: The single write 0x98@0x55 selects the query view (`read_mode_o` = 2'b10). It is accepted only from the array or identifier view.
- R9: Every write presented while `busy_i` or `start_o` is high is ignored, and no start is issued while the engine is busy.
- R10: A program whose target block (the top 4 address bits) has its `prot_bits` bit set produces no start and leaves `err_o` unchanged.
- R11: While `wp_n` is low, blocks 14 and 15 are protected whatever their `prot_bits` are. Other blocks are not affected.
- R12: At each start, `owner_bank_o` holds the bank of the target (address bit 15). That bank keeps ownership until the next start.
- R13: The three writes 0xAA@0x555, 0x55@0x2AA, 0x90@0x555 select the identifier view (`read_mode_o` = 2'b01). A failure pulse on `eng_fail` sets `err_o` the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; the low byte carries the command |
| word_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| hv_pin | input | 1 | High-voltage program pin asserted |
| wp_n | input | 1 | Write protect, active low |
| prot_bits | input | 2**BLK_W | Per-block protection bits |
| busy_i | input | 1 | Program engine busy |
| eng_fail | input | 1 | Program engine failure pulse |
| start_o | output | 1 | One-cycle program start |
| op_code_o | output | 2 | 00 single, 01 paired word, 10 four byte |
| op_addr_o | output | ADDR_W | Aligned target address |
| op_data_o | output | 2*DATA_W | Packed program data |
| owner_bank_o | output | BANK_W | Bank owning the last program |
| read_mode_o | output | 2 | 00 array, 01 identifier, 10 query |
| bypass_o | output | 1 | Bypass mode active |
| err_o | output | 1 | Sticky engine error |

## Verification
Each write is registered on the rising edge at which its strobe is sampled. The view, bypass and error outputs change on that same edge. The start pulse and its operation fields appear for the one cycle that follows the final write of a sequence. The bench applies every write and pin change at a falling edge and advances its reference model just after the next rising edge. At each falling edge it then compares all outputs against the model, so every result is checked in the exact cycle it is due. An engine model in the bench raises busy on the edge after a start, which lets the checks cover writes that land in the start cycle and writes that land during the busy window.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_UNL1,
        S_UNL2,
        S_PROG,
        S_FAST,
        S_BYP_IDLE,
        S_BYP_PROG,
        S_BYP_EXIT
    } dec_state_e;

    typedef enum logic [1:0] {
        RM_ARRAY   = 2'b00,
        RM_AUTOSEL = 2'b01,
        RM_CFI     = 2'b10
    } rd_mode_e;

    typedef enum logic [1:0] {
        OPC_SINGLE = 2'b00,
        OPC_DWORD  = 2'b01,
        OPC_QUAD   = 2'b10
    } op_code_e;

endpackage

// File: rtl/flash_blk_guard.sv
module flash_blk_guard #(
    parameter int BLK_W  = 4,
    parameter int BANK_W = 1
) (
    input  logic [BLK_W-1:0]      blk_idx,
    input  logic [(1<<BLK_W)-1:0] prot_bits,
    input  logic                  wp_n,
    output logic                  protected_o,
    output logic [BANK_W-1:0]     bank_o
);
    localparam int NBLK = 1 << BLK_W;

    logic [NBLK-1:0] boot_mask;

    // the two highest blocks form the hardware-guarded boot pair
    for (genvar g = 0; g < NBLK; g++) begin : g_boot
        assign boot_mask[g] = (g >= NBLK - 2);
    end

    always_comb begin
        protected_o = prot_bits[blk_idx] | (~wp_n & boot_mask[blk_idx]);
        bank_o      = blk_idx[BLK_W-1 -: BANK_W];
    end
endmodule

// File: rtl/flash_lane_packer.sv
module flash_lane_packer
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld,
    input  logic                  clr,
    input  op_code_e              mode,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     data,
    output logic [ADDR_W-1:0]     op_addr_o,
    output logic [2*DATA_W-1:0]   op_data_o
);
    localparam int OPW = 2 * DATA_W;

    logic [OPW-1:0]    data_d;
    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        data_d = clr ? '0 : op_data_o;
        addr_d = op_addr_o;
        unique case (mode)
            OPC_DWORD: begin
                if (addr[0]) data_d[OPW-1 -: DATA_W] = data;
                else         data_d[DATA_W-1:0]      = data;
                if (clr) addr_d = {addr[ADDR_W-1:1], 1'b0};
            end
            OPC_QUAD: begin
                data_d[{addr[1:0], 3'b000} +: 8] = data[7:0];
                if (clr) addr_d = {addr[ADDR_W-1:2], 2'b00};
            end
            default: begin
                data_d = {{(OPW-DATA_W){1'b0}}, data};
                addr_d = addr;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_data_o <= '0;
            op_addr_o <= '0;
        end else if (ld) begin
            op_data_o <= data_d;
            op_addr_o <= addr_d;
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int BLK_W  = 4,
    parameter int BANK_W = 1,
    parameter logic [ADDR_W-1:0] UNL_ADDR1 = 'h555,
    parameter logic [ADDR_W-1:0] UNL_ADDR2 = 'h2AA,
    parameter logic [ADDR_W-1:0] CFI_ADDR  = 'h055,
    parameter logic [7:0] UNL_DATA1    = 8'hAA,
    parameter logic [7:0] UNL_DATA2    = 8'h55,
    parameter logic [7:0] CMD_RESET    = 8'hF0,
    parameter logic [7:0] CMD_AUTOSEL  = 8'h90,
    parameter logic [7:0] CMD_PROG     = 8'hA0,
    parameter logic [7:0] CMD_BYPASS   = 8'h20,
    parameter logic [7:0] CMD_CFI      = 8'h98,
    parameter logic [7:0] CMD_FAST     = 8'h50,
    parameter logic [7:0] CMD_BYP_EXIT = 8'h00
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_stb,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  word_mode,
    input  logic                  hv_pin,
    input  logic                  wp_n,
    input  logic [(1<<BLK_W)-1:0] prot_bits,
    input  logic                  busy_i,
    input  logic                  eng_fail,
    output logic                  start_o,
    output logic [1:0]            op_code_o,
    output logic [ADDR_W-1:0]     op_addr_o,
    output logic [2*DATA_W-1:0]   op_data_o,
    output logic [BANK_W-1:0]     owner_bank_o,
    output logic [1:0]            read_mode_o,
    output logic                  bypass_o,
    output logic                  err_o
);
    dec_state_e state_q, state_d;
    rd_mode_e   mode_q, mode_d, ret_q, ret_d;
    op_code_e   opc_q, opc_d, pk_mode;
    logic [1:0] cnt_q, cnt_d;
    logic       wide_q, wide_d;
    logic       err_q, err_d;
    logic       hv_q, start_q, go;
    logic       pk_ld, pk_clr;
    logic       blk_prot;
    logic [BANK_W-1:0] tgt_bank, bank_q;
    logic       acc, hv_rise, hv_fall, misalign, last_lane;
    logic [7:0] cmd;

    flash_blk_guard #(.BLK_W(BLK_W), .BANK_W(BANK_W)) i_guard (
        .blk_idx     (wr_addr[ADDR_W-1 -: BLK_W]),
        .prot_bits   (prot_bits),
        .wp_n        (wp_n),
        .protected_o (blk_prot),
        .bank_o      (tgt_bank)
    );

    flash_lane_packer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (pk_ld),
        .clr       (pk_clr),
        .mode      (pk_mode),
        .addr      (wr_addr),
        .data      (wr_data),
        .op_addr_o (op_addr_o),
        .op_data_o (op_data_o)
    );

    assign cmd     = wr_data[7:0];
    assign acc     = wr_stb & ~busy_i & ~start_q;
    assign hv_rise = hv_pin & ~hv_q;
    assign hv_fall = ~hv_pin & hv_q;
    assign misalign = wide_q ? (wr_addr[ADDR_W-1:1] != op_addr_o[ADDR_W-1:1])
                             : (wr_addr[ADDR_W-1:2] != op_addr_o[ADDR_W-1:2]);
    assign last_lane = (cnt_q == (wide_q ? 2'd1 : 2'd3));

    // next-state and sequence decode
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        ret_d   = ret_q;
        err_d   = err_q | eng_fail;
        cnt_d   = cnt_q;
        wide_d  = wide_q;
        opc_d   = opc_q;
        go      = 1'b0;
        pk_ld   = 1'b0;
        pk_clr  = 1'b0;
        pk_mode = opc_q;
        if (hv_rise) begin
            state_d = S_BYP_IDLE;
        end else if (hv_fall) begin
            state_d = S_IDLE;
            mode_d  = RM_ARRAY;
        end else if (acc) begin
            unique case (state_q)
                S_IDLE: begin
                    if (cmd == CMD_RESET) begin
                        mode_d = (mode_q == RM_CFI) ? ret_q : RM_ARRAY;
                        err_d  = 1'b0;
                    end else if (wr_addr == CFI_ADDR && cmd == CMD_CFI && mode_q != RM_CFI) begin
                        ret_d  = mode_q;
                        mode_d = RM_CFI;
                    end else if (wr_addr == UNL_ADDR1 && cmd == UNL_DATA1) begin
                        state_d = S_UNL1;
                    end else if (wr_addr == UNL_ADDR1 && cmd == CMD_FAST) begin
                        state_d = S_FAST;
                        cnt_d   = 2'd0;
                        wide_d  = word_mode;
                        opc_d   = word_mode ? OPC_DWORD : OPC_QUAD;
                    end else begin
                        mode_d = RM_ARRAY;
                    end
                end
                S_UNL1: begin
                    if (wr_addr == UNL_ADDR2 && cmd == UNL_DATA2) begin
                        state_d = S_UNL2;
                    end else begin
                        state_d = S_IDLE;
                        mode_d  = RM_ARRAY;
                    end
                end
                S_UNL2: begin
                    state_d = S_IDLE;
                    mode_d  = RM_ARRAY;
                    if (wr_addr == UNL_ADDR1) begin
                        if (cmd == CMD_RESET) begin
                            mode_d = (mode_q == RM_CFI) ? ret_q : RM_ARRAY;
                            err_d  = 1'b0;
                        end else if (cmd == CMD_AUTOSEL) begin
                            mode_d = RM_AUTOSEL;
                        end else if (cmd == CMD_PROG) begin
                            state_d = S_PROG;
                            opc_d   = OPC_SINGLE;
                        end else if (cmd == CMD_BYPASS) begin
                            state_d = S_BYP_IDLE;
                        end
                    end
                end
                S_PROG: begin
                    pk_ld   = 1'b1;
                    pk_clr  = 1'b1;
                    pk_mode = OPC_SINGLE;
                    go      = ~blk_prot;
                    state_d = S_IDLE;
                    mode_d  = RM_ARRAY;
                end
                S_FAST: begin
                    if (cnt_q != 2'd0 && misalign) begin
                        state_d = S_IDLE;
                        mode_d  = RM_ARRAY;
                    end else begin
                        pk_ld  = 1'b1;
                        pk_clr = (cnt_q == 2'd0);
                        if (last_lane) begin
                            go      = ~blk_prot;
                            state_d = S_IDLE;
                            mode_d  = RM_ARRAY;
                        end else begin
                            cnt_d = cnt_q + 2'd1;
                        end
                    end
                end
                S_BYP_IDLE: begin
                    if (cmd == CMD_PROG) begin
                        state_d = S_BYP_PROG;
                        opc_d   = OPC_SINGLE;
                    end else if (cmd == CMD_AUTOSEL) begin
                        state_d = S_BYP_EXIT;
                    end
                end
                S_BYP_PROG: begin
                    pk_ld   = 1'b1;
                    pk_clr  = 1'b1;
                    pk_mode = OPC_SINGLE;
                    go      = ~blk_prot;
                    state_d = S_BYP_IDLE;
                end
                S_BYP_EXIT: begin
                    if (cmd == CMD_BYP_EXIT && !hv_pin) begin
                        state_d = S_IDLE;
                        mode_d  = RM_ARRAY;
                        err_d   = 1'b0;
                    end else begin
                        state_d = S_BYP_IDLE;
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            mode_q  <= RM_ARRAY;
            ret_q   <= RM_ARRAY;
            cnt_q   <= '0;
            wide_q  <= 1'b0;
            opc_q   <= OPC_SINGLE;
            err_q   <= 1'b0;
            hv_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            ret_q   <= ret_d;
            cnt_q   <= cnt_d;
            wide_q  <= wide_d;
            opc_q   <= opc_d;
            err_q   <= err_d;
            hv_q    <= hv_pin;
        end
    end

    // registered outputs toward the engine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            bank_q  <= '0;
        end else begin
            start_q <= go;
            if (go) bank_q <= tgt_bank;
        end
    end

    assign start_o      = start_q;
    assign op_code_o    = opc_q;
    assign owner_bank_o = bank_q;
    assign read_mode_o  = mode_q;
    assign err_o        = err_q;
    assign bypass_o     = (state_q == S_BYP_IDLE) || (state_q == S_BYP_PROG)
                       || (state_q == S_BYP_EXIT);

    p_busy_nostart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> !start_o);
    p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    p_hv_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hv_pin |=> bypass_o);
    p_owner_bank_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> owner_bank_o == op_addr_o[ADDR_W-1 -: BANK_W]);
    p_mode_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        read_mode_o != 2'b11);
endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        word_mode = 1'b0;
    logic        hv_pin = 1'b0;
    logic        wp_n = 1'b1;
    logic [15:0] prot_bits = '0;
    logic        busy_i = 1'b0;
    logic        eng_fail = 1'b0;
    logic        start_o;
    logic [1:0]  op_code_o;
    logic [15:0] op_addr_o;
    logic [31:0] op_data_o;
    logic        owner_bank_o;
    logic [1:0]  read_mode_o;
    logic        bypass_o;
    logic        err_o;

    always #2 clk = ~clk;

    flash_cmd_decoder i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .word_mode(word_mode), .hv_pin(hv_pin), .wp_n(wp_n),
        .prot_bits(prot_bits), .busy_i(busy_i), .eng_fail(eng_fail),
        .start_o(start_o), .op_code_o(op_code_o), .op_addr_o(op_addr_o),
        .op_data_o(op_data_o), .owner_bank_o(owner_bank_o),
        .read_mode_o(read_mode_o), .bypass_o(bypass_o), .err_o(err_o));

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    logic  chk_en = 1'b0;
    logic  fail_next = 1'b0;
    int    ecnt = 0;

    // reference model state
    int          m_st = 0;
    int          m_mode = 0;
    int          m_ret = 0;
    int          m_cnt = 0;
    logic        m_wide = 1'b0;
    logic        m_err = 1'b0;
    logic [15:0] m_base = '0;
    logic [31:0] m_data = '0;
    logic        e_start = 1'b0;
    int          e_op = 0;
    logic [15:0] e_addr = '0;
    logic [31:0] e_data = '0;
    logic        e_bank = 1'b0;

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    function automatic logic is_prot(input logic [15:0] a);
        return prot_bits[a[15:12]] || (!wp_n && a[15:12] >= 4'd14);
    endfunction

    task automatic issue(input int op, input logic [15:0] a, input logic [31:0] d);
        if (!is_prot(a)) begin
            e_start = 1'b1; e_op = op; e_addr = a; e_data = d; e_bank = a[15];
        end
    endtask

    task automatic model_wr(input logic [15:0] a, input logic [15:0] d);
        logic [7:0] c = d[7:0];
        case (m_st)
            0: begin
                if (c == 8'hF0) begin m_mode = (m_mode == 2) ? m_ret : 0; m_err = 0; end
                else if (a == 16'h55 && c == 8'h98 && m_mode != 2) begin m_ret = m_mode; m_mode = 2; end
                else if (a == 16'h555 && c == 8'hAA) m_st = 1;
                else if (a == 16'h555 && c == 8'h50) begin m_st = 4; m_cnt = 0; m_wide = word_mode; end
                else m_mode = 0;
            end
            1: if (a == 16'h2AA && c == 8'h55) m_st = 2; else begin m_st = 0; m_mode = 0; end
            2: begin
                m_st = 0;
                if (a == 16'h555 && c == 8'hF0) begin m_mode = (m_mode == 2) ? m_ret : 0; m_err = 0; end
                else if (a == 16'h555 && c == 8'h90) m_mode = 1;
                else if (a == 16'h555 && c == 8'hA0) begin m_st = 3; m_mode = 0; end
                else if (a == 16'h555 && c == 8'h20) begin m_st = 5; m_mode = 0; end
                else m_mode = 0;
            end
            3: begin m_st = 0; m_mode = 0; issue(0, a, {16'h0, d}); end
            4: begin
                if (m_cnt == 0) begin
                    m_base = m_wide ? {a[15:1], 1'b0} : {a[15:2], 2'b00};
                    m_data = '0;
                end
                if (m_cnt != 0 && (m_wide ? (a[15:1] != m_base[15:1]) : (a[15:2] != m_base[15:2]))) begin
                    m_st = 0; m_mode = 0;
                end else begin
                    if (m_wide) m_data[a[0]*16 +: 16] = d;
                    else        m_data[a[1:0]*8 +: 8] = c;
                    if (m_cnt == (m_wide ? 1 : 3)) begin
                        m_st = 0; m_mode = 0;
                        issue(m_wide ? 1 : 2, m_base, m_data);
                    end else m_cnt++;
                end
            end
            5: if (c == 8'hA0) m_st = 6; else if (c == 8'h90) m_st = 7;
            6: begin m_st = 5; issue(0, a, {16'h0, d}); end
            7: if (c == 8'h00 && !hv_pin) begin m_st = 0; m_mode = 0; m_err = 0; end else m_st = 5;
            default: m_st = 0;
        endcase
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        logic ign;
        @(negedge clk);
        ign = busy_i || start_o;
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_stb = 1'b0;
        if (!ign) model_wr(a, d);
    endtask

    task automatic set_hv(input logic v);
        @(negedge clk);
        hv_pin = v;
        @(posedge clk); #1;
        if (v) m_st = 5; else begin m_st = 0; m_mode = 0; end
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (busy_i) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic unlock3(input logic [7:0] c);
        wr(16'h555, 16'hAA); wr(16'h2AA, 16'h55); wr(16'h555, {8'h0, c});
    endtask

    // program engine model
    always @(posedge clk) begin
        if (eng_fail) m_err = 1'b1;
        eng_fail <= 1'b0;
        if (start_o) begin
            busy_i <= 1'b1; ecnt = 5;
        end else if (busy_i) begin
            ecnt--;
            if (ecnt == 0) begin busy_i <= 1'b0; eng_fail <= fail_next; end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_en) begin
            cmp("read_mode", {30'b0, read_mode_o}, m_mode);
            cmp("bypass", {31'b0, bypass_o}, {31'b0, (m_st >= 5)});
            cmp("err", {31'b0, err_o}, {31'b0, m_err});
            cmp("start", {31'b0, start_o}, {31'b0, e_start});
            if (start_o && e_start) begin
                cmp("op_code", {30'b0, op_code_o}, e_op);
                cmp("op_addr", {16'b0, op_addr_o}, {16'b0, e_addr});
                cmp("op_data", op_data_o, e_data);
                cmp("owner_bank R12", {31'b0, owner_bank_o}, {31'b0, e_bank});
            end
            e_start = 1'b0;
        end
    end

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1"; // reset state
        cmp("reset start", {31'b0, start_o}, 0);
        cmp("reset mode", {30'b0, read_mode_o}, 0);
        chk_en = 1'b1;

        cur_req = "R3";
        unlock3(8'hA0); wr(16'h1234, 16'hBEEF); wait_idle();

        cur_req = "R13";
        unlock3(8'h90);
        cur_req = "R8";
        wr(16'h55, 16'h98);
        cur_req = "R2";
        wr(16'h0, 16'hF0);
        wr(16'h0, 16'hF0);
        cur_req = "R8";
        wr(16'h55, 16'h98);
        cur_req = "R2";
        unlock3(8'hF0);

        cur_req = "R1";
        wr(16'h555, 16'hAA); wr(16'h123, 16'h00);
        unlock3(8'h90); wr(16'h777, 16'h33);

        cur_req = "R4";
        word_mode = 1'b0;
        wr(16'h555, 16'h50);
        wr(16'h2002, 16'h11); wr(16'h2000, 16'h22); wr(16'h2003, 16'h33); wr(16'h2001, 16'h44);
        wait_idle();
        wr(16'h555, 16'h50); wr(16'h3000, 16'h01); wr(16'h3004, 16'h02);
        wr(16'h3001, 16'h03); wr(16'h3002, 16'h04);

        cur_req = "R5";
        word_mode = 1'b1;
        wr(16'h555, 16'h50); wr(16'h4001, 16'hABCD); wr(16'h4000, 16'h1234);
        wait_idle();
        wr(16'h555, 16'h50); wr(16'h4000, 16'h1111); wr(16'h4002, 16'h2222);
        word_mode = 1'b0;

        cur_req = "R13";
        fail_next = 1'b1;
        unlock3(8'hA0); wr(16'h0600, 16'h0042); wait_idle();
        fail_next = 1'b0;
        cur_req = "R2";
        wr(16'h0, 16'hF0);

        cur_req = "R9";
        unlock3(8'hA0); wr(16'h0700, 16'h0001);
        wr(16'h555, 16'hAA);
        wait_idle();
        wr(16'h2AA, 16'h55); wr(16'h555, 16'h90);

        cur_req = "R10";
        prot_bits[5] = 1'b1;
        unlock3(8'hA0); wr(16'h5000, 16'h0009); wait_idle();
        prot_bits[5] = 1'b0;

        cur_req = "R11";
        wp_n = 1'b0;
        unlock3(8'hA0); wr(16'hF000, 16'h0001); wait_idle();
        unlock3(8'hA0); wr(16'hE000, 16'h0002); wait_idle();
        unlock3(8'hA0); wr(16'hD000, 16'h0003); wait_idle();
        wp_n = 1'b1;
        unlock3(8'hA0); wr(16'hF000, 16'h0004); wait_idle();

        cur_req = "R6";
        unlock3(8'h20);
        wr(16'h0, 16'hA0); wr(16'h0100, 16'h5A5A); wait_idle();
        wr(16'h0, 16'hF0);
        wr(16'h0, 16'h90); wr(16'h0, 16'h00);

        cur_req = "R7";
        set_hv(1'b1);
        wr(16'h0, 16'hA0); wr(16'h8800, 16'h0077); wait_idle();
        wr(16'h0, 16'h90); wr(16'h0, 16'h00);
        set_hv(1'b0);

        cur_req = "R12";
        unlock3(8'hA0); wr(16'h9000, 16'h00C3); wait_idle();
        unlock3(8'hA0); wr(16'h1000, 16'h00C4); wait_idle();

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule